// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block keeps the tags of a set-associative cache and answers, for each requested address, whether that block is resident. It stores no data. Only the tag and a valid flag are kept for each way of each set. The address is split into three fields. The low bits give the byte position inside a block, the next bits select a set, and the remaining upper bits form the tag. The tag is stored in place: it is the address with the set and offset bits forced to zero, not shifted down. On a lookup, all ways of the selected set are compared at the same time.

On a miss the block installs the new tag straight away. It picks the lowest-numbered way that is not yet valid. Only when every way of the set is valid does it ask an external replacement unit for a victim way, through a request/acknowledge handshake. While that handshake is open the block takes no new requests. Each response reports the outcome (hit or miss), the way that was hit or filled, and whether a fill displaced a valid entry. The replacement unit uses that last flag to update its own state.

Top module: `tag_directory`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` and `victim_req` are low, `req_ready` is high, and every way of every set is invalid, so the first access to any set is a miss into way 0.
- R2: The set index is `req_addr[OFF_W +: SET_W]`, where OFF_W = log2(BLK_BYTES) and SET_W = log2(SETS). The tag is every bit from OFF_W+SET_W upward. The offset bits do not take part in the lookup, so two addresses in the same block give the same result.
- R3: A hit needs a stored tag equal to the request tag in a way whose valid flag is set. An address with a different tag in the same set misses.
- R4: An accepted request (`req_valid` and `req_ready` high at a clock edge) is answered in the next cycle. When `rsp_valid` is high, exactly one of `rsp_hit` and `rsp_miss` is high.
- R5: On a miss in a set that still has an invalid way, the lowest-numbered invalid way is filled. It is reported in `rsp_way` with `rsp_evict` low.
- R6: After a miss fills a way, a later access to the same block hits and reports that way.
- R7: On a miss in a set whose ways are all valid, `victim_req` rises in the next cycle and no response is given. `victim_req` stays high and `req_ready` stays low until `victim_ack`.
- R8: In the cycle after `victim_ack` is sampled high with `victim_req`, the block responds with a miss, `rsp_evict` high and `rsp_way` equal to the sampled `victim_way`. That way now holds the new tag, and the tag it held before misses.
- R9: A reset issued after the directory has been filled invalidates every entry, so previously resident blocks miss again.
- R10: A request presented while `req_ready` is low is ignored. It gets no response and installs no tag.
- R11: Sets are independent. Fills and evictions in one set do not change hit or miss results in another set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Byte address to look up |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Block was resident |
| rsp_miss | output | 1 | Block was not resident and has been installed |
| rsp_way | output | log2(WAYS) | Way that hit or was filled |
| rsp_evict | output | 1 | Fill replaced a valid entry |
| victim_req | output | 1 | Asking the replacement unit for a victim way |
| victim_ack | input | 1 | Replacement unit supplies `victim_way` |
| victim_way | input | log2(WAYS) | Way chosen for eviction |

## Verification
The hardest state to reach from the ports is a full set that receives a miss, because every way must first be filled with distinct tags. The stimulus fills every way of every set in a small four-set, four-way configuration. It then sends new tags to force victim handshakes, holds the acknowledge back for a cycle, and presents a stray request while the handshake is open. A long pseudo-random sequence over a handful of tags then keeps sets full and churning, and its results are compared with a reference model kept in the bench.

// File: rtl/tagdir_pkg.sv
// Shared types for the tag directory.
package tagdir_pkg;

    // Controller state: idle accepts lookups, wait holds for a victim way.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } dir_state_t;

endpackage

// File: rtl/tagdir_store.sv
// Tag and valid storage for all sets and ways.
// Reads one whole set combinationally and writes one way per cycle.
// Assumes SETS and WAYS are powers of two, so every index is in range.
// Only the valid flags are reset; tag contents are don't-care while invalid.
module tagdir_store #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 8,
    parameter int SETS   = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    output logic [WAYS-1:0][ADDR_W-1:0]  rd_tags,
    output logic [WAYS-1:0]              rd_valid,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [ADDR_W-1:0]            wr_tag
);

    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [ADDR_W-1:0]         tag_q [SETS][WAYS];

    // Valid flags: cleared by reset, set by every fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    // Tag array: the written tag lands in the chosen way of the chosen set.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_set];

    // One read path per way of the selected set.
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tags[w] = tag_q[rd_set][w];
    end

    // R5: a fill leaves its way valid.
    p_fill_sets_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_set)][$past(wr_way)]);

endmodule

// File: rtl/tagdir_lookup.sv
// Parallel tag compare and way selection for one set.
// Reports the lowest matching valid way and the lowest invalid way.
// Purely combinational; assumes the caller masks the tag the same way as stored.
module tagdir_lookup #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [ADDR_W-1:0]            key_tag,
    input  logic [WAYS-1:0][ADDR_W-1:0]  tags,
    input  logic [WAYS-1:0]              valid,
    output logic                         hit,
    output logic [WAY_W-1:0]             hit_way,
    output logic                         has_free,
    output logic [WAY_W-1:0]             free_way
);

    logic [WAYS-1:0] match;

    // One comparator per way; a match needs the valid flag too.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == key_tag);
    end

    // Priority pick: scanning downward leaves the lowest set bit as the winner.
    always_comb begin
        hit      = |match;
        has_free = ~&valid;
        hit_way  = '0;
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_way = WAY_W'(i);
            end
            if (!valid[i]) begin
                free_way = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/tagdir_ctrl.sv
// Request sequencing for the tag directory.
// Accepts a lookup in idle, registers the result one cycle later, and holds
// in a wait state while the replacement unit chooses a victim for a full set.
// Assumes victim_way is a legal way index whenever victim_ack is high.
module tagdir_ctrl
    import tagdir_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 8,
    parameter int SETS   = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [SET_W-1:0]   req_set,
    input  logic [ADDR_W-1:0]  req_tag,
    input  logic               lk_hit,
    input  logic [WAY_W-1:0]   lk_hit_way,
    input  logic               lk_free,
    input  logic [WAY_W-1:0]   lk_free_way,
    output logic               victim_req,
    input  logic               victim_ack,
    input  logic [WAY_W-1:0]   victim_way,
    output logic               wr_en,
    output logic [SET_W-1:0]   wr_set,
    output logic [WAY_W-1:0]   wr_way,
    output logic [ADDR_W-1:0]  wr_tag,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic [WAY_W-1:0]   rsp_way,
    output logic               rsp_evict
);

    dir_state_t        state_q;
    logic [SET_W-1:0]  pend_set_q;
    logic [ADDR_W-1:0] pend_tag_q;
    logic              fire;
    logic              fill_now;
    logic              evict_now;

    assign req_ready  = (state_q == ST_IDLE);
    assign victim_req = (state_q == ST_WAIT);
    assign fire       = req_valid && req_ready;
    assign fill_now   = fire && !lk_hit && lk_free;
    assign evict_now  = victim_req && victim_ack;

    // Write port select: a free-way fill from the live request or an eviction.
    always_comb begin
        wr_en  = fill_now || evict_now;
        wr_set = evict_now ? pend_set_q : req_set;
        wr_way = evict_now ? victim_way : lk_free_way;
        wr_tag = evict_now ? pend_tag_q : req_tag;
    end

    // State and pending miss: enter wait on a miss into a full set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_set_q <= '0;
            pend_tag_q <= '0;
        end else if (fire && !lk_hit && !lk_free) begin
            state_q    <= ST_WAIT;
            pend_set_q <= req_set;
            pend_tag_q <= req_tag;
        end else if (evict_now) begin
            state_q    <= ST_IDLE;
        end
    end

    // Response register: one cycle after a hit, a fill or a victim grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_way   <= '0;
            rsp_evict <= 1'b0;
        end else begin
            rsp_valid <= (fire && (lk_hit || lk_free)) || evict_now;
            rsp_hit   <= fire && lk_hit;
            rsp_miss  <= fill_now || evict_now;
            rsp_evict <= evict_now;
            rsp_way   <= evict_now ? victim_way : (lk_hit ? lk_hit_way : lk_free_way);
        end
    end

    // R4: a valid response carries exactly one outcome.
    p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R4: every accepted request is answered or parked next cycle.
    p_answer_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (rsp_valid || victim_req));

    // R7: an open victim request stays open and silent until acknowledged.
    p_victim_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_req && !victim_ack) |=> (victim_req && !rsp_valid && !req_ready));

    // R8: a granted victim is reported as an eviction into that way.
    p_evict_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evict_now |=> (rsp_valid && rsp_miss && rsp_evict && rsp_way == $past(victim_way)));

    // R10: nothing is written while waiting unless the victim is granted.
    p_ignore_in_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_req && !victim_ack) |-> !wr_en);

endmodule

// File: rtl/tag_directory.sv
// Set-associative tag directory top level.
// Splits the address into offset, set and in-place tag, looks the set up,
// and hands fills to the controller. Assumes BLK_BYTES, SETS and WAYS are
// powers of two with SETS and WAYS at least 2.
module tag_directory #(
    parameter int ADDR_W    = 32,
    parameter int WAYS      = 8,
    parameter int BLK_BYTES = 64,
    parameter int SETS      = 32,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int SET_W    = $clog2(SETS),
    localparam int WAY_W    = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_evict,
    output logic              victim_req,
    input  logic              victim_ack,
    input  logic [WAY_W-1:0]  victim_way
);

    localparam logic [ADDR_W-1:0] TAG_MASK = {ADDR_W{1'b1}} << (OFF_W + SET_W);

    logic [SET_W-1:0]            req_set;
    logic [ADDR_W-1:0]           req_tag;
    logic [WAYS-1:0][ADDR_W-1:0] set_tags;
    logic [WAYS-1:0]             set_valid;
    logic                        lk_hit;
    logic [WAY_W-1:0]            lk_hit_way;
    logic                        lk_free;
    logic [WAY_W-1:0]            lk_free_way;
    logic                        wr_en;
    logic [SET_W-1:0]            wr_set;
    logic [WAY_W-1:0]            wr_way;
    logic [ADDR_W-1:0]           wr_tag;

    assign req_set = req_addr[OFF_W +: SET_W];
    assign req_tag = req_addr & TAG_MASK;

    tagdir_store #(
        .ADDR_W (ADDR_W),
        .WAYS   (WAYS),
        .SETS   (SETS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (req_set),
        .rd_tags  (set_tags),
        .rd_valid (set_valid),
        .wr_en    (wr_en),
        .wr_set   (wr_set),
        .wr_way   (wr_way),
        .wr_tag   (wr_tag)
    );

    tagdir_lookup #(
        .ADDR_W (ADDR_W),
        .WAYS   (WAYS)
    ) u_lookup (
        .key_tag  (req_tag),
        .tags     (set_tags),
        .valid    (set_valid),
        .hit      (lk_hit),
        .hit_way  (lk_hit_way),
        .has_free (lk_free),
        .free_way (lk_free_way)
    );

    tagdir_ctrl #(
        .ADDR_W (ADDR_W),
        .WAYS   (WAYS),
        .SETS   (SETS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_set     (req_set),
        .req_tag     (req_tag),
        .lk_hit      (lk_hit),
        .lk_hit_way  (lk_hit_way),
        .lk_free     (lk_free),
        .lk_free_way (lk_free_way),
        .victim_req  (victim_req),
        .victim_ack  (victim_ack),
        .victim_way  (victim_way),
        .wr_en       (wr_en),
        .wr_set      (wr_set),
        .wr_way      (wr_way),
        .wr_tag      (wr_tag),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_miss    (rsp_miss),
        .rsp_way     (rsp_way),
        .rsp_evict   (rsp_evict)
    );

    // R1: the cycle after reset has no response and no open victim request.
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !victim_req && req_ready));

endmodule

// File: tb/tag_directory_test.sv
// Self-checking bench: small geometry, reference model of tags and valid flags.
module tag_directory_test;

    localparam int ADDR_W = 16;
    localparam int WAYS   = 4;
    localparam int BLK    = 16;
    localparam int SETS   = 4;
    localparam int OFF_W  = 4;
    localparam int SET_W  = 2;
    localparam int WAY_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid, rsp_hit, rsp_miss, rsp_evict, victim_req;
    logic [WAY_W-1:0]  rsp_way;
    logic              victim_ack = 1'b0;
    logic [WAY_W-1:0]  victim_way = '0;

    int checks = 0;
    int fails  = 0;

    logic [ADDR_W-1:0] m_tag [SETS][WAYS];
    logic              m_val [SETS][WAYS];

    always #2 clk = ~clk;

    tag_directory #(
        .ADDR_W (ADDR_W), .WAYS (WAYS), .BLK_BYTES (BLK), .SETS (SETS)
    ) uut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .rsp_valid (rsp_valid), .rsp_hit (rsp_hit),
        .rsp_miss (rsp_miss), .rsp_way (rsp_way), .rsp_evict (rsp_evict),
        .victim_req (victim_req), .victim_ack (victim_ack), .victim_way (victim_way)
    );

    task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] rsp_vec();
        return {8'd0, 1'b0, victim_req, req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_evict, 1'b0} | 16'(rsp_way);
    endfunction

    function automatic logic [15:0] mk_vec(input bit vr, input bit rd, input bit v,
                                           input bit h, input bit m, input bit e, input int w);
        return {8'd0, 1'b0, vr, rd, v, h, m, e, 1'b0} | 16'(w);
    endfunction

    task automatic model_clear();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_val[s][w] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // One lookup; expected outcome computed from the model.
    task automatic access(input logic [ADDR_W-1:0] addr, input int vic, input string rq);
        int set, hw, fw;
        logic [ADDR_W-1:0] tag;
        set = int'(addr[OFF_W +: SET_W]);
        tag = addr & ({ADDR_W{1'b1}} << (OFF_W + SET_W));
        hw = -1; fw = -1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (m_val[set][w] && m_tag[set][w] == tag) hw = w;
            if (!m_val[set][w]) fw = w;
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        if (hw >= 0) begin
            check({rq, " hit"}, rsp_vec(), mk_vec(0, 1, 1, 1, 0, 0, hw));
        end else if (fw >= 0) begin
            check({rq, " fill R5"}, rsp_vec(), mk_vec(0, 1, 1, 0, 1, 0, fw));
            m_val[set][fw] = 1'b1;
            m_tag[set][fw] = tag;
        end else begin
            check("R7 victim request", rsp_vec(), mk_vec(1, 0, 0, 0, 0, 0, rsp_way));
            // R10: stray request while not ready must be ignored.
            req_valid = 1'b1;
            req_addr  = addr ^ 16'h8000;
            @(negedge clk);
            check("R7 R10 held", rsp_vec(), mk_vec(1, 0, 0, 0, 0, 0, rsp_way));
            victim_way = WAY_W'(vic);
            victim_ack = 1'b1;
            @(negedge clk);
            victim_ack = 1'b0;
            req_valid  = 1'b0;
            check("R8 eviction", rsp_vec(), mk_vec(0, 1, 1, 0, 1, 1, vic));
            m_tag[set][vic] = tag;
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int set, input int off);
        return ADDR_W'((tag << (OFF_W + SET_W)) | (set << OFF_W) | off);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", rsp_vec(), mk_vec(0, 1, 0, 0, 0, 0, 0));

        // R1 R5: fill every way of every set in order.
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                access(mk_addr(w + 1, s, (w * 3) % BLK), 0, "R1 R5 first fill");

        // R2 R6 R11: same blocks at other offsets hit their ways.
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                access(mk_addr(w + 1, s, BLK - 1 - w), 0, "R2 R6 R11 repeat");

        // R3 R7 R8: a new tag in each full set forces an eviction.
        for (int s = 0; s < SETS; s++)
            access(mk_addr(9, s, 0), (s + 1) % WAYS, "R3 R8 new tag");
        // R8: evicted tags now miss; R10: stray tags were not installed.
        for (int s = 0; s < SETS; s++) begin
            access(mk_addr(s + 2, s, 5), s % WAYS, "R8 evicted tag");
            access(mk_addr(9, s, 0) ^ 16'h8000, 3, "R10 stray tag");
        end

        // R3 R11: mixed pseudo-random traffic over few tags.
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(mk_addr(int'(lfsr[15:8]) % 6, int'(lfsr[5:4]), int'(lfsr[3:0])),
                   int'(lfsr[7:6]), "R3 R11 random");
        end

        // R9: reset invalidates everything; resident block misses into way 0.
        do_reset();
        check("R1 R9 reset state", rsp_vec(), mk_vec(0, 1, 0, 0, 0, 0, 0));
        access(mk_addr(9, 1, 0), 0, "R9 after reset");
        access(mk_addr(9, 1, 7), 0, "R9 R6 refill");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule